// File: doc/BRIEF.md
# Time-Aware Gate Control Scheduler

This block drives the per-queue transmit gates of an Ethernet egress port from a programmable gate control list. Each list word pairs a duration in nanoseconds with a mask of open queues. Once enabled, the scheduler waits for an absolute start instant derived from a base time. It then plays the list entry by entry against a running time-of-day and restarts the list every cycle time. A last entry that straddles the cycle boundary may be stretched by a bounded extension.

Time-of-day, base time and cycle time each arrive as a seconds word and a nanoseconds word, and the block combines them into one nanosecond count internally. The list is loaded through a simple write port that checks field widths and applies the hold/release forcing of gate bit 0 before storing. The base time, cycle time, extension and list length are latched when a schedule starts. They take effect again only after the enable has been dropped and raised.

Top module: `tas_gate_sched`

## Requirements
- R1: A list word holds the interval in bits [W-1:0] and the gate mask in bits [31:W]; each entry's mask drives `gate_mask` for exactly its interval in nanoseconds, after which the next entry takes over.
- R2: A write is refused when `wr_interval` is 2^W or more, when `wr_gates` is 2^(32-W) or more, or when `wr_cmd` is 3. The cycle after a refused write `wr_reject` is 1, and the stored entry keeps its old contents. After an accepted write it is 0.
- R3: The `wr_cmd` code 0 stores the mask unchanged, code 1 stores it with bit 0 set, and code 2 stores it with bit 0 cleared.
- R4: A base time later than the time-of-day at enable starts entry 0 at exactly the base time.
- R5: A base time at or before the time-of-day T at enable starts entry 0 at base + (n+1)·cycle, with n = floor((T − base) / cycle).
- R6: All time values combine as seconds·10^9 + nanoseconds, so that seconds rollovers and whole-second cycle parts are honoured.
- R7: Each time the cycle time elapses, the list restarts at entry 0, even if entries remain. A list that ends before the cycle keeps its last mask until the restart.
- R8: The last entry may already be running when the cycle boundary arrives, with its end no more than `cyc_ext` ns past that boundary. It then runs to completion, and the next cycle begins at its end. Otherwise the list restarts at the boundary.
- R9: A cycle time of zero, a `cyc_ext` of 2^(W+7) or more, or a list length of zero keeps the schedule from starting and all gates open.
- R10: While `sched_en` is low, and from the start request until the start instant, `gate_mask` is all ones; it returns to all ones the cycle after `sched_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_en | input | 1 | Scheduler enable |
| tod_sec | input | 32 | Time-of-day, seconds |
| tod_ns | input | 32 | Time-of-day, nanoseconds (0..999999999) |
| base_sec | input | 32 | Base time, seconds |
| base_ns | input | 32 | Base time, nanoseconds |
| cyc_sec | input | 32 | Cycle time, whole seconds |
| cyc_ns | input | 32 | Cycle time, nanosecond part |
| cyc_ext | input | 32 | Cycle extension limit in ns |
| list_len | input | AW | Number of list entries in use (less than DEPTH) |
| wr_en | input | 1 | List write strobe |
| wr_addr | input | AW | List write address |
| wr_interval | input | 32 | Entry interval in ns |
| wr_gates | input | 32 | Entry gate mask |
| wr_cmd | input | 2 | Entry command: 0 set, 1 set-and-hold, 2 set-and-release |
| wr_reject | output | 1 | Previous cycle's write was refused |
| gate_mask | output | 32-W | Current per-queue gate-open mask |

## Verification
Assertions check on every cycle that the gates are open after the enable falls and that the entry index never passes the last loaded entry. They also check that an extension is only held on the last entry within the allowed window, that consecutive cycle starts are never closer than the cycle time, and that a schedule enters the list only at or after its computed start. Stored words for hold and release commands are checked for the forced bit 0. Only the bench scenarios show the exact nanosecond at which each mask appears. This covers start-instant arithmetic for past and future bases, truncation against extension across a sweep of cycle lengths, seconds rollover, and that refused writes leave the list unchanged.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

  typedef enum logic [1:0] {
    CMD_SET     = 2'd0,
    CMD_HOLD    = 2'd1,
    CMD_RELEASE = 2'd2,
    CMD_RSVD    = 2'd3
  } gcl_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } gcl_state_e;

  localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;

  // Seconds/nanoseconds pair to one nanosecond count.
  function automatic logic [63:0] to_ns(input logic [31:0] sec, input logic [31:0] ns);
    return ({32'd0, sec} * NS_PER_SEC) + {32'd0, ns};
  endfunction

  // First cycle start not earlier than now: base if strictly ahead,
  // else the first base + k*cycle strictly after now.
  function automatic logic [63:0] first_start(input logic [63:0] now,
                                              input logic [63:0] base,
                                              input logic [63:0] cyc);
    logic [63:0] n;
    if (base > now || cyc == 64'd0) return base;
    n = (now - base) / cyc;
    return base + ((n + 64'd1) * cyc);
  endfunction

endpackage

// File: rtl/gcl_entry_ram.sv
module gcl_entry_ram
  import gcl_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_interval,
  input  logic [31:0]   wr_gates,
  input  logic [1:0]    wr_cmd,
  output logic          wr_reject,
  output logic [31:0]   rd0_word,
  input  logic [AW-1:0] rdn_addr,
  output logic [31:0]   rdn_word
);
  localparam int GW = 32 - W;

  logic [31:0] mem [DEPTH];

  logic ivl_big, gates_big, cmd_bad, wr_ok;
  logic [GW-1:0] forced_mask;

  assign ivl_big   = |wr_interval[31:W];
  assign gates_big = |wr_gates[31:GW];
  assign cmd_bad   = (wr_cmd == CMD_RSVD);
  assign wr_ok     = wr_en && !ivl_big && !gates_big && !cmd_bad;

  always_comb begin
    forced_mask = wr_gates[GW-1:0];
    if (wr_cmd == CMD_HOLD)    forced_mask[0] = 1'b1;
    if (wr_cmd == CMD_RELEASE) forced_mask[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= {forced_mask, wr_interval[W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_reject <= 1'b0;
    else        wr_reject <= wr_en && !wr_ok;
  end

  assign rd0_word = mem[0];
  assign rdn_word = mem[rdn_addr];

  // R3
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_cmd == CMD_HOLD) |=> mem[$past(wr_addr)][W] == 1'b1);
  // R3
  release_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_cmd == CMD_RELEASE) |=> mem[$past(wr_addr)][W] == 1'b0);

endmodule

// File: rtl/gcl_sequencer.sv
module gcl_sequencer
  import gcl_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_ok,
  input  logic [63:0]   now_t,
  input  logic [63:0]   base_t,
  input  logic [63:0]   cyc_t,
  input  logic [31:0]   ext,
  input  logic [AW-1:0] len,
  input  logic [31:0]   rd0_word,
  output logic [AW-1:0] rdn_addr,
  input  logic [31:0]   rdn_word,
  output logic [31:0]   gate_out
);
  localparam int GW = 32 - W;

  gcl_state_e    st;
  logic [63:0]   start_q, cyc_q, cyc_start, ent_end;
  logic [31:0]   ext_q;
  logic [AW-1:0] last_q, idx;
  logic          list_done, ext_hold;
  logic [GW-1:0] mask_q;

  // named internal events
  logic [63:0] cyc_end, restart_base, start_calc;
  logic        running, cyc_due, ent_due, hold_begin, do_restart, do_advance, list_end;

  assign running    = (st == ST_RUN);
  assign start_calc = first_start(now_t, base_t, cyc_t);
  assign cyc_end    = cyc_start + cyc_q;
  assign cyc_due    = now_t >= cyc_end;
  assign ent_due    = now_t >= ent_end;
  assign hold_begin = running && !ext_hold && cyc_due && (idx == last_q) && !list_done &&
                      !ent_due && ((ent_end - cyc_end) <= {32'd0, ext_q});
  assign do_restart = (st == ST_WAIT && now_t >= start_q) ||
                      (running && (ext_hold ? ent_due : (cyc_due && !hold_begin)));
  assign restart_base = (st == ST_WAIT) ? start_q : (ext_hold ? ent_end : cyc_end);
  assign do_advance = running && !ext_hold && !cyc_due && !list_done && ent_due && (idx != last_q);
  assign list_end   = running && !ext_hold && !cyc_due && !list_done && ent_due && (idx == last_q);
  assign rdn_addr   = idx + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  start_q <= '0;  cyc_q <= '0;  ext_q <= '0;  last_q <= '0;
      idx <= '0;  cyc_start <= '0;  ent_end <= '0;
      list_done <= 1'b0;  ext_hold <= 1'b0;  mask_q <= '1;
    end else if (!en) begin
      st <= ST_IDLE;  mask_q <= '1;  list_done <= 1'b0;  ext_hold <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (cfg_ok) begin
        start_q <= start_calc;
        cyc_q   <= cyc_t;
        ext_q   <= ext;
        last_q  <= len - AW'(1);
        st      <= ST_WAIT;
      end
    end else if (do_restart) begin
      st        <= ST_RUN;
      idx       <= '0;
      cyc_start <= restart_base;
      ent_end   <= restart_base + {{(64-W){1'b0}}, rd0_word[W-1:0]};
      mask_q    <= rd0_word[31:W];
      list_done <= 1'b0;
      ext_hold  <= 1'b0;
    end else if (hold_begin) begin
      ext_hold <= 1'b1;
    end else if (do_advance) begin
      idx     <= rdn_addr;
      ent_end <= ent_end + {{(64-W){1'b0}}, rdn_word[W-1:0]};
      mask_q  <= rdn_word[31:W];
    end else if (list_end) begin
      list_done <= 1'b1;
    end
  end

  assign gate_out = {{W{1'b0}}, mask_q};

  // R10
  gates_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> mask_q == '1);
  // R1
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> idx <= last_q);
  // R8
  ext_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hold |-> (idx == last_q && !list_done && (ent_end - cyc_end) <= {32'd0, ext_q}));
  // R7
  cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(st) == ST_RUN && cyc_start != $past(cyc_start))
      |-> (cyc_start - $past(cyc_start)) >= $past(cyc_q));
  // R5
  start_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(st) == ST_WAIT) |-> (cyc_start == start_q && $past(now_t) >= start_q));

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import gcl_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int GW    = 32 - W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched_en,
  input  logic [31:0]   tod_sec,
  input  logic [31:0]   tod_ns,
  input  logic [31:0]   base_sec,
  input  logic [31:0]   base_ns,
  input  logic [31:0]   cyc_sec,
  input  logic [31:0]   cyc_ns,
  input  logic [31:0]   cyc_ext,
  input  logic [AW-1:0] list_len,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_interval,
  input  logic [31:0]   wr_gates,
  input  logic [1:0]    wr_cmd,
  output logic          wr_reject,
  output logic [GW-1:0] gate_mask
);
  localparam logic [63:0] EXT_LIMIT = 64'd1 << (W + 7);

  logic [63:0]   now_t, base_t, cyc_t;
  logic          cfg_ok;
  logic [31:0]   rd0_word, rdn_word, gate_full;
  logic [AW-1:0] rdn_addr;

  assign now_t  = to_ns(tod_sec, tod_ns);
  assign base_t = to_ns(base_sec, base_ns);
  assign cyc_t  = to_ns(cyc_sec, cyc_ns);
  assign cfg_ok = (cyc_t != 64'd0) && ({32'd0, cyc_ext} < EXT_LIMIT) && (list_len != '0);

  gcl_entry_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_interval(wr_interval),
    .wr_gates(wr_gates), .wr_cmd(wr_cmd), .wr_reject(wr_reject),
    .rd0_word(rd0_word), .rdn_addr(rdn_addr), .rdn_word(rdn_word)
  );

  gcl_sequencer #(.W(W), .DEPTH(DEPTH), .AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .en(sched_en), .cfg_ok(cfg_ok),
    .now_t(now_t), .base_t(base_t), .cyc_t(cyc_t), .ext(cyc_ext), .len(list_len),
    .rd0_word(rd0_word), .rdn_addr(rdn_addr), .rdn_word(rdn_word),
    .gate_out(gate_full)
  );

  assign gate_mask = gate_full[GW-1:0];

  // R9
  bad_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && !cfg_ok && gate_mask == '1) |=> gate_mask == '1);

endmodule

// File: tb/tas_gate_sched_tb_top.sv
module tas_gate_sched_tb_top;
  localparam int W = 16;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int GW = 32 - W;
  localparam longint unsigned NSS = 64'd1_000_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_en = 1'b0;
  logic [31:0] tod_sec = '0, tod_ns = '0, base_sec = '0, base_ns = '0;
  logic [31:0] cyc_sec = '0, cyc_ns = '0, cyc_ext = '0;
  logic [AW-1:0] list_len = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_interval = '0, wr_gates = '0;
  logic [1:0] wr_cmd = '0;
  logic wr_reject;
  logic [GW-1:0] gate_mask;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model of the list the bench loads (entry 1 hold-forced, entry 2 release-forced)
  int unsigned ivl [3] = '{5, 3, 4};
  logic [GW-1:0] msk [3] = '{16'h0012, 16'h0040 | 16'h0001, 16'h00F1 & ~16'h0001};
  longint unsigned m_s, m_c, m_ext;

  always #2.5 clk = ~clk;

  tas_gate_sched #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .base_sec(base_sec), .base_ns(base_ns),
    .cyc_sec(cyc_sec), .cyc_ns(cyc_ns), .cyc_ext(cyc_ext), .list_len(list_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_interval(wr_interval), .wr_gates(wr_gates),
    .wr_cmd(wr_cmd), .wr_reject(wr_reject), .gate_mask(gate_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_tod(input longint unsigned t);
    tod_sec = 32'(t / NSS);
    tod_ns  = 32'(t % NSS);
  endtask

  // expected gate mask at time t, by walking cycle starts from the start instant
  function automatic logic [GW-1:0] exp_mask(input longint unsigned t);
    longint unsigned cs, nb, e, acc;
    longint unsigned pre = 8, tot = 12;
    if (t < m_s) return '1;
    cs = m_s;
    nb = (pre < m_c && tot > m_c && tot - m_c <= m_ext) ? cs + tot : cs + m_c;
    while (t >= nb) begin
      cs = nb;
      nb = (pre < m_c && tot > m_c && tot - m_c <= m_ext) ? cs + tot : cs + m_c;
    end
    e = t - cs;
    acc = 0;
    for (int k = 0; k < 3; k++) begin
      acc += ivl[k];
      if (e < acc) return msk[k];
    end
    return msk[2];
  endfunction

  task automatic wr(input int a, input logic [31:0] iv, input logic [31:0] g,
                    input logic [1:0] c, input logic exp_rej, input string tag);
    wr_en = 1'b1; wr_addr = AW'(a); wr_interval = iv; wr_gates = g; wr_cmd = c;
    tick();
    wr_en = 1'b0;
    chk(tag, {31'd0, wr_reject}, {31'd0, exp_rej});
  endtask

  task automatic run(input longint unsigned base, input longint unsigned csec,
                     input longint unsigned cns, input longint unsigned ext,
                     input longint unsigned t0, input int n, input string tag);
    sched_en = 1'b0;
    tick();
    chk("R10 disabled", 32'(gate_mask), 32'hFFFF);
    base_sec = 32'(base / NSS); base_ns = 32'(base % NSS);
    cyc_sec = 32'(csec); cyc_ns = 32'(cns); cyc_ext = 32'(ext);
    list_len = AW'(3);
    m_c = csec * NSS + cns; m_ext = ext;
    if (base > t0) m_s = base;
    else begin
      m_s = base;
      while (m_s <= t0) m_s += m_c;
    end
    drive_tod(t0);
    sched_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      tick();
      chk(tag, 32'(gate_mask), 32'(exp_mask(t0 + longint'(k))));
      drive_tod(t0 + longint'(k) + 1);
    end
  endtask

  task automatic bad_cfg(input longint unsigned csec, input longint unsigned cns,
                         input longint unsigned ext, input int len, input string tag);
    sched_en = 1'b0;
    tick();
    cyc_sec = 32'(csec); cyc_ns = 32'(cns); cyc_ext = 32'(ext);
    list_len = AW'(len); base_sec = 0; base_ns = 32'd50;
    drive_tod(64'd40);
    sched_en = 1'b1;
    for (int k = 0; k < 30; k++) begin
      tick();
      chk(tag, 32'(gate_mask), 32'hFFFF);
      drive_tod(64'd41 + longint'(k));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R10 reset mask", 32'(gate_mask), 32'hFFFF);
    chk("R2 reset reject", {31'd0, wr_reject}, 32'd0);

    // R3: set, hold, release loads; R2 refused writes to entry 1
    wr(0, 5, 32'h12, 2'd0, 1'b0, "R3 set");
    wr(1, 3, 32'h40, 2'd1, 1'b0, "R3 hold");
    wr(2, 4, 32'hF1, 2'd2, 1'b0, "R3 release");
    wr(1, 32'h1_0000, 32'h3, 2'd0, 1'b1, "R2 interval too wide");
    wr(1, 3, 32'h1_0000, 2'd0, 1'b1, "R2 mask too wide");
    wr(1, 3, 32'h7, 2'd3, 1'b1, "R2 reserved cmd");
    wr(3, 32'hFFFF, 32'hFFFF, 2'd0, 1'b0, "R2 widest accepted");

    // R1 R7 R8 sweep of cycle length and extension, future and past bases
    for (int c = 6; c <= 16; c++) begin
      for (int x = 0; x <= 3; x++) begin
        run(64'd150, 0, c, x, 64'd100, 110, "R1 R4 R7 R8 future base");
        run(64'd7, 0, c, x, 64'd100, 70, "R1 R5 R7 R8 past base");
      end
    end
    // R5 base equal to now
    run(64'd300, 0, 20, 0, 64'd300, 60, "R5 base equals now");
    // R6 seconds rollover, and whole-second cycle part
    run(3 * NSS + 999_999_990, 0, 20, 0, 3 * NSS + 999_999_980, 80, "R6 seconds rollover");
    run(64'd500, 1, 0, 0, 64'd480, 60, "R6 whole-second cycle");
    // largest legal extension is accepted
    run(64'd150, 0, 20, (64'd1 << 23) - 1, 64'd100, 80, "R9 max extension legal");

    // R10 disable mid-run
    sched_en = 1'b0;
    tick();
    chk("R10 disable mid-run", 32'(gate_mask), 32'hFFFF);

    // R9 invalid configurations
    bad_cfg(0, 0, 0, 3, "R9 zero cycle");
    bad_cfg(0, 20, 64'd1 << 23, 3, "R9 extension too large");
    bad_cfg(0, 20, 0, 0, "R9 zero length");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule